// File: doc/BRIEF.md
# Program Sequencer with Two-Level Return Stack

This block holds the program counter of a 16-bit signal processor and produces the instruction fetch address every cycle. Each cycle the instruction decoder presents an operation code. The sequencer can clear itself, hold, step forward, jump by a signed 12-bit displacement, branch on a condition flag, jump to a register value, call a subroutine with either kind of target, or return.

Subroutine return addresses are kept in a small hardware stack. The stack is two entries deep by default. A call saves the address of the calling instruction. A return resumes at the saved address plus one. The block flags a call made while the stack is full, and a return made while it is empty. The program memory address is the registered program counter, so every operation shows on the address output one clock after it is presented.

Top module: `pfc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, or when `op` is 0 (clear), the next address is 0, the stack becomes empty and `stk_err` is 0.
- R2: `op` 1 (hold), and any code from 10 to 15, keeps the address unchanged. Every operation other than a refused call or return drives `stk_err` to 0 on the next cycle.
- R3: `op` 2 (step) makes the next address the current address plus 1, modulo 2^16.
- R4: `op` 3 (relative jump) adds `imm` to the address. `imm` is sign-extended from bit 11.
- R5: `op` 4 takes the relative target when `flag` is 1, and otherwise steps by 1. `op` 5 takes the relative target when `flag` is 0, and otherwise steps by 1.
- R6: `op` 6 (absolute jump) loads the address from `opa`.
- R7: `op` 7 (relative call) and `op` 8 (absolute call) save the current address on the stack. The next address is the relative target for `op` 7 and `opa` for `op` 8.
- R8: `op` 9 (return) removes the most recently saved address. The next address is that saved address plus 1.
- R9: The stack holds at most 2 addresses, and returns come back in last-in, first-out order.
- R10: A call made with a full stack, or a return made with an empty stack, sets `stk_err` to 1 on the next cycle. The stack is left unchanged. The address update still happens: a refused return goes to address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 4 | Operation code from the decoder |
| imm | input | 12 | Signed displacement from the instruction word |
| opa | input | 16 | Register operand used as an absolute target |
| flag | input | 1 | Condition flag for the conditional branches |
| pm_addr | output | 16 | Program memory address (registered PC) |
| stk_err | output | 1 | Stack overflow or underflow on the previous operation |

## Verification
The bench uses the default parameters: a 16-bit address, a 12-bit displacement and a stack depth of 2. With a depth of only 2, random call and return streams reach the full stack and the empty stack within a few operations, so both refusal paths are exercised often. Negative displacements near address 0 and near the top of the range exercise wrap-around of the 16-bit address.

// File: rtl/pfc_pkg.sv
// Package: shared operation codes for the program sequencer.
// Assumes the decoder presents one 4-bit code per cycle. Codes 10..15 act as hold.
package pfc_pkg;

    typedef enum logic [3:0] {
        OP_CLEAR    = 4'd0,
        OP_HOLD     = 4'd1,
        OP_STEP     = 4'd2,
        OP_JREL     = 4'd3,
        OP_BR_SET   = 4'd4,
        OP_BR_CLR   = 4'd5,
        OP_JABS     = 4'd6,
        OP_CALL_REL = 4'd7,
        OP_CALL_ABS = 4'd8,
        OP_RETURN   = 4'd9
    } pfc_op_e;

endpackage

// File: rtl/pfc_next_pc.sv
// Module: combinational next-address selection and stack command decode.
// Assumes the return value from the stack already reads 0 when the stack is empty.
module pfc_next_pc
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12
) (
    input  pfc_op_e             op_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [ADDR_W-1:0]   reg_i,
    input  logic                cond_i,
    input  logic [ADDR_W-1:0]   ret_addr_i,
    output logic [ADDR_W-1:0]   pc_nxt_o,
    output logic                push_o,
    output logic                pop_o,
    output logic                clear_o
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_addr;

    // Sign-extend the displacement and form the two candidate targets.
    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        seq_addr = pc_i + ADDR_W'(1);
        rel_addr = pc_i + disp_ext;
    end

    // Select the next program counter and the stack command for this operation.
    always_comb begin
        pc_nxt_o = pc_i;
        push_o   = 1'b0;
        pop_o    = 1'b0;
        clear_o  = 1'b0;
        unique case (op_i)
            OP_CLEAR: begin
                pc_nxt_o = '0;
                clear_o  = 1'b1;
            end
            OP_HOLD:     pc_nxt_o = pc_i;
            OP_STEP:     pc_nxt_o = seq_addr;
            OP_JREL:     pc_nxt_o = rel_addr;
            OP_BR_SET:   pc_nxt_o = cond_i ? rel_addr : seq_addr;
            OP_BR_CLR:   pc_nxt_o = cond_i ? seq_addr : rel_addr;
            OP_JABS:     pc_nxt_o = reg_i;
            OP_CALL_REL: begin
                pc_nxt_o = rel_addr;
                push_o   = 1'b1;
            end
            OP_CALL_ABS: begin
                pc_nxt_o = reg_i;
                push_o   = 1'b1;
            end
            OP_RETURN: begin
                pc_nxt_o = ret_addr_i + ADDR_W'(1);
                pop_o    = 1'b1;
            end
            default:     pc_nxt_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pfc_ret_stack.sv
// Module: last-in first-out store for return addresses, DEPTH entries deep.
// Assumes push and pop are never requested together. A refused push or pop
// leaves both the entries and the fill count untouched.
module pfc_ret_stack #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                push_i,
    input  logic                pop_i,
    input  logic [ADDR_W-1:0]   push_data_i,
    output logic [ADDR_W-1:0]   top_o,
    output logic                full_o,
    output logic                empty_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic              do_push;
    logic              do_pop;

    // Qualify the requests against the current fill level.
    always_comb begin
        full_o  = (count_q == CNT_MAX);
        empty_o = (count_q == '0);
        do_push = push_i && !full_o && !clear_i;
        do_pop  = pop_i && !empty_o && !clear_i;
        count_o = count_q;
    end

    // Track how many slots hold a saved address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
        end else if (do_push) begin
            count_q <= count_q + CNT_W'(1);
        end else if (do_pop) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    // One register per slot; a push writes the slot at the current fill level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (do_push && (count_q == CNT_W'(g))) begin
                slot_q[g] <= push_data_i;
            end
        end
    end

    // Present the most recent entry, or zero when nothing is stored.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (count_q == CNT_W'(i + 1)) begin
                top_o = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/pfc_top.sv
// Module: program sequencer top. It holds the PC register and the registered
// error flag, and connects the next-address logic to the return stack.
// Assumes the decoder has already resolved hazards and delay slots.
module pfc_top
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12,
    parameter int DEPTH  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op,
    input  logic [DISP_W-1:0]   imm,
    input  logic [ADDR_W-1:0]   opa,
    input  logic                flag,
    output logic [ADDR_W-1:0]   pm_addr,
    output logic                stk_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    pfc_op_e           op_e;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] ret_addr;
    logic              push;
    logic              pop;
    logic              clear;
    logic              full;
    logic              empty;
    logic              err_q;
    logic [CNT_W-1:0]  stk_count;

    // Interpret the raw decoder code as an operation.
    always_comb op_e = pfc_op_e'(op);

    pfc_next_pc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_next (
        .op_i       (op_e),
        .pc_i       (pc_q),
        .disp_i     (imm),
        .reg_i      (opa),
        .cond_i     (flag),
        .ret_addr_i (ret_addr),
        .pc_nxt_o   (pc_nxt),
        .push_o     (push),
        .pop_o      (pop),
        .clear_o    (clear)
    );

    pfc_ret_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (pc_q),
        .top_o       (ret_addr),
        .full_o      (full),
        .empty_o     (empty),
        .count_o     (stk_count)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nxt;
        end
    end

    // Registered flag for a refused call or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (push && full) || (pop && empty);
        end
    end

    // Drive the outputs.
    always_comb begin
        pm_addr = pc_q;
        stk_err = err_q;
    end

endmodule

// File: rtl/pfc_checker.sv
// Module: property checker for pfc_top, attached through bind below.
// Assumes the opcode values listed in pfc_pkg.
module pfc_checker #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 12,
    parameter int DEPTH  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [3:0]                 op,
    input logic [DISP_W-1:0]          imm,
    input logic [ADDR_W-1:0]          opa,
    input logic                       flag,
    input logic [ADDR_W-1:0]          pm_addr,
    input logic                       stk_err,
    input logic [$clog2(DEPTH+1)-1:0] stk_count
);

    localparam int EXT_W = ADDR_W - DISP_W;

    // R1: reset forces address 0
    p_reset_addr_r1: assert property (@(posedge clk)
        !rst_n |=> (pm_addr == '0 && !stk_err));

    p_clear_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'd0 |=> (pm_addr == '0 && stk_count == '0 && !stk_err));

    // R2
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'd1 |=> $stable(pm_addr));

    p_err_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == 4'd7 || op == 4'd8 || op == 4'd9) |=> !stk_err);

    // R3
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'd2 |=> pm_addr == $past(pm_addr) + ADDR_W'(1));

    // R4
    p_jrel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'd3 |=> pm_addr == $past(pm_addr) + {{EXT_W{$past(imm[DISP_W-1])}}, $past(imm)});

    // R6
    p_jabs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op == 4'd6 |=> pm_addr == $past(opa));

    // R9
    p_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= ($clog2(DEPTH+1))'(DEPTH));

    // R10
    p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd9 && stk_count == '0) |=> (stk_err && pm_addr == ADDR_W'(1) && stk_count == '0));

    p_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 4'd7 || op == 4'd8) && stk_count == ($clog2(DEPTH+1))'(DEPTH))
        |=> (stk_err && $stable(stk_count)));

endmodule

bind pfc_top pfc_checker #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .DEPTH  (DEPTH)
) u_pfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .imm       (imm),
    .opa       (opa),
    .flag      (flag),
    .pm_addr   (pm_addr),
    .stk_err   (stk_err),
    .stk_count (stk_count)
);

// File: tb/test_pfc_top.sv
`timescale 1ns/1ps
module test_pfc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd1;
    logic [11:0] imm = '0;
    logic [15:0] opa = '0;
    logic        flag = 1'b0;
    logic [15:0] pm_addr;
    logic        stk_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference model state
    logic [15:0] m_pc = '0;
    logic [15:0] m_stk [2];
    int          m_cnt = 0;
    logic        m_err = 1'b0;
    string       m_tag = "R1";

    always #2 clk = ~clk;

    pfc_top i_pfc_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .imm     (imm),
        .opa     (opa),
        .flag    (flag),
        .pm_addr (pm_addr),
        .stk_err (stk_err)
    );

    function automatic logic [15:0] sx(input logic [11:0] d);
        return {{4{d[11]}}, d};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Update the model for one operation, following the requirements.
    task automatic model(input logic [3:0] o, input logic [11:0] d, input logic [15:0] a, input logic f);
        m_err = 1'b0;
        case (o)
            4'd0: begin m_pc = 16'd0; m_cnt = 0; m_tag = "R1"; end
            4'd2: begin m_pc = m_pc + 16'd1; m_tag = "R3"; end
            4'd3: begin m_pc = m_pc + sx(d); m_tag = "R4"; end
            4'd4: begin m_pc = f ? m_pc + sx(d) : m_pc + 16'd1; m_tag = "R5"; end
            4'd5: begin m_pc = !f ? m_pc + sx(d) : m_pc + 16'd1; m_tag = "R5"; end
            4'd6: begin m_pc = a; m_tag = "R6"; end
            4'd7, 4'd8: begin
                if (m_cnt == 2) begin m_err = 1'b1; m_tag = "R10"; end
                else begin m_stk[m_cnt] = m_pc; m_cnt++; m_tag = "R7"; end
                m_pc = (o == 4'd7) ? m_pc + sx(d) : a;
            end
            4'd9: begin
                if (m_cnt == 0) begin m_err = 1'b1; m_pc = 16'd1; m_tag = "R10"; end
                else begin m_cnt--; m_pc = m_stk[m_cnt] + 16'd1; m_tag = "R8"; end
            end
            default: m_tag = "R2";
        endcase
    endtask

    // Apply one operation at a falling edge and compare one cycle later.
    task automatic step(input logic [3:0] o, input logic [11:0] d, input logic [15:0] a, input logic f);
        op = o; imm = d; opa = a; flag = f;
        model(o, d, a, f);
        @(negedge clk);
        check({m_tag, " addr"}, pm_addr, m_pc);
        check({m_tag, " err"}, {15'd0, stk_err}, {15'd0, m_err});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 addr", pm_addr, 16'd0);
        check("R1 err", {15'd0, stk_err}, 16'd0);
        rst_n = 1'b1;
        // R3, R2
        step(4'd2, 12'h000, 16'h0, 1'b0);
        step(4'd2, 12'h000, 16'h0, 1'b0);
        step(4'd1, 12'hfff, 16'hffff, 1'b1);
        step(4'd12, 12'h123, 16'h5555, 1'b1);
        // R4: negative displacement wraps below zero
        step(4'd3, 12'h800, 16'h0, 1'b0);
        step(4'd3, 12'h7ff, 16'h0, 1'b0);
        // R5: both branch senses, both flag values
        step(4'd4, 12'h010, 16'h0, 1'b1);
        step(4'd4, 12'h010, 16'h0, 1'b0);
        step(4'd5, 12'h020, 16'h0, 1'b0);
        step(4'd5, 12'h020, 16'h0, 1'b1);
        // R6
        step(4'd6, 12'h000, 16'hfffe, 1'b0);
        step(4'd2, 12'h000, 16'h0, 1'b0);
        // R7, R9, R10: fill the stack, overflow, then drain and underflow
        step(4'd7, 12'h100, 16'h0, 1'b0);
        step(4'd8, 12'h000, 16'h4000, 1'b0);
        step(4'd8, 12'h000, 16'h7000, 1'b0);
        step(4'd2, 12'h000, 16'h0, 1'b0);
        step(4'd9, 12'h000, 16'h0, 1'b0);
        step(4'd9, 12'h000, 16'h0, 1'b0);
        step(4'd9, 12'h000, 16'h0, 1'b0);
        // R1: clear empties the stack
        step(4'd7, 12'h004, 16'h0, 1'b0);
        step(4'd0, 12'h000, 16'h0, 1'b0);
        step(4'd9, 12'h000, 16'h0, 1'b0);
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] o;
            o = 4'($urandom % 16);
            if (o == 4'd0 && ($urandom % 8) != 0) o = 4'd2;
            step(o, 12'($urandom), 16'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule